// File: doc/BRIEF.md
# E1 Automatic Alarm Generator

This block sits beside the receive framer of an E1 line interface. It watches the receive side and decides whether the transmitter should replace its traffic with an alarm indication signal (all ones) or flag a remote alarm indication back to the far end. Each automatic alarm has its own enable. The transmit formatter reads `send_ais` and `send_rai` as steady levels.

Three receive defects drive both alarms: loss of basic frame alignment, an all-ones signal arriving from upstream, and loss of carrier. The block detects carrier loss itself by counting consecutive zero bits. One clock is one line bit. Two run lengths can be selected: 255 bits (about 125 µs) or 2048 bits (about 1 ms).

When CRC4 is in use, the block also times the multiframe search. It counts 125 µs frame ticks from the moment basic frame alignment is gained:
- After 1024 ticks (128 ms) with no multiframe alignment, the remote alarm is raised.
- After 3200 ticks (400 ms), the remote alarm is held steadily.

Enabling both automatic alarms at once is not a legal setting. The block flags it and lets the all-ones alarm win.

Top module: `e1_alarm_gen`

## Requirements
- R1: With `long_zero_sel`=0, `carrier_lost` rises on the clock edge that samples the 255th consecutive zero on `rx_bit`. After 254 zeros it is still low.
- R2: With `long_zero_sel`=1, `carrier_lost` rises on the edge that samples the 2048th consecutive zero. After 2047 zeros it is still low.
- R3: A one sampled on `rx_bit` clears both the zero run and `carrier_lost` at that edge, so a fresh run must reach the full threshold again.
- R4: `send_ais` is high exactly when `auto_ais_en`=1 and at least one of these holds: `fas_lost`, `ais_rx` or `carrier_lost`.
- R5: With `auto_rai_en`=1 and `auto_ais_en`=0, `send_rai` is high whenever `fas_lost`, `ais_rx` or `carrier_lost` is high. With `auto_rai_en`=0, `send_rai` is low.
- R6: With `auto_rai_en`=1 and `crc4_en`=1, `send_rai` rises once 1024 frame ticks have been counted with frame alignment held and `mf_found` low. If `mf_found` rises before 3200 ticks, the remote alarm from the search timer drops at the next edge.
- R7: The search timer counts a tick only while `fas_lost`=0, `crc4_en`=1 and `mf_found`=0. Any of `fas_lost`=1, `crc4_en`=0 or `mf_found`=1 returns the timer to zero.
- R8: After 3200 counted ticks the remote alarm becomes constant. It stays high even if `mf_found` rises, until `fas_lost`=1 or `crc4_en`=0 is sampled.
- R9: `cfg_illegal` is high exactly when both enables are high. In that state `send_rai` is forced low whenever `send_ais` is high.
- R10: After reset, with all inputs low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received data bit, one per clock |
| frame_tick | input | 1 | One-clock pulse per 125 µs frame |
| fas_lost | input | 1 | Basic frame alignment lost |
| ais_rx | input | 1 | All-ones signal being received |
| crc4_en | input | 1 | CRC4 multiframe operation enabled |
| mf_found | input | 1 | CRC4 multiframe alignment found |
| auto_ais_en | input | 1 | Enable automatic all-ones alarm |
| auto_rai_en | input | 1 | Enable automatic remote alarm |
| long_zero_sel | input | 1 | 0: 255-zero carrier threshold, 1: 2048-zero threshold |
| send_ais | output | 1 | Transmit all-ones alarm |
| send_rai | output | 1 | Transmit remote alarm indication |
| carrier_lost | output | 1 | Receive carrier loss detected |
| cfg_illegal | output | 1 | Both automatic alarms enabled |

## Verification
The bench probes each threshold one step short and exactly on the limit:
- Carrier loss is checked at 254 and 255 zeros, and at 2047 and 2048 zeros. A detector that is off by one, or that ignores the select input, declares loss a bit early or late.
- The search timer is checked at 1023 and 1024 ticks.

The timer tests also look for a timer that wrongly keeps running. One such design counts during alignment loss or with CRC4 off. Another fails to restart when alignment is lost for a single cycle. Either would raise the remote alarm too early in the gating test.

The 3199-versus-3200 tick case separates a recoverable late search from the constant alarm. A design without the sticky state drops the alarm when the multiframe appears. A design whose sticky state never clears keeps the alarm after alignment is lost again.

The illegal-setting test drives a defect with both enables high. A design that lacks the priority rule would send both alarms at once.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;

  // Saturating increment used by both run counters.
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned cap);
    return (cur >= cap) ? cap : cur + 1;
  endfunction

  // Carrier-loss run length selected by the threshold input.
  function automatic int unsigned zero_limit(input logic long_sel,
                                             input int unsigned short_lim,
                                             input int unsigned long_lim);
    return long_sel ? long_lim : short_lim;
  endfunction

endpackage

// File: rtl/e1_zero_run_det.sv
module e1_zero_run_det
  import e1_alarm_pkg::*;
#(
  parameter int unsigned SHORT_LIM = 255,
  parameter int unsigned LONG_LIM  = 2048,
  localparam int unsigned CW = $clog2(LONG_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit,
  input  logic          long_sel,
  output logic [CW-1:0] run_len,
  output logic          lost
);
  int unsigned next_len;
  int unsigned limit;

  always_comb begin
    next_len = sat_inc(int'(run_len), LONG_LIM);
    limit    = zero_limit(long_sel, SHORT_LIM, LONG_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      lost    <= 1'b0;
    end else if (rx_bit) begin
      run_len <= '0;
      lost    <= 1'b0;
    end else begin
      run_len <= CW'(next_len);
      if (next_len >= limit) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/e1_mf_search_timer.sv
module e1_mf_search_timer
  import e1_alarm_pkg::*;
#(
  parameter int unsigned SOFT_FRAMES = 1024,
  parameter int unsigned HARD_FRAMES = 3200,
  localparam int unsigned FW = $clog2(HARD_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic fas_lost,
  input  logic crc4_en,
  input  logic mf_found,
  output logic late,
  output logic abandon
);
  logic [FW-1:0] frames;
  logic          restart;
  logic          searching;
  int unsigned   next_frames;

  assign restart   = fas_lost || !crc4_en;
  assign searching = !restart && !mf_found;

  always_comb next_frames = sat_inc(int'(frames), HARD_FRAMES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames  <= '0;
      abandon <= 1'b0;
    end else begin
      if (!searching)
        frames <= '0;
      else if (frame_tick)
        frames <= FW'(next_frames);

      if (restart)
        abandon <= 1'b0;
      else if (searching && frame_tick && next_frames >= HARD_FRAMES)
        abandon <= 1'b1;
    end
  end

  assign late = (int'(frames) >= SOFT_FRAMES);
endmodule

// File: rtl/e1_alarm_arbiter.sv
module e1_alarm_arbiter (
  input  logic auto_ais_en,
  input  logic auto_rai_en,
  input  logic crc4_en,
  input  logic rx_defect,
  input  logic mf_late,
  input  logic mf_abandon,
  output logic send_ais,
  output logic send_rai,
  output logic cfg_illegal
);
  logic rai_want;

  always_comb begin
    cfg_illegal = auto_ais_en && auto_rai_en;
    send_ais    = auto_ais_en && rx_defect;
    rai_want    = auto_rai_en && (rx_defect || (crc4_en && (mf_late || mf_abandon)));
    send_rai    = rai_want && !(cfg_illegal && send_ais);
  end
endmodule

// File: rtl/e1_alarm_gen.sv
module e1_alarm_gen #(
  parameter int unsigned SHORT_ZEROS = 255,
  parameter int unsigned LONG_ZEROS  = 2048,
  parameter int unsigned SOFT_FRAMES = 1024,
  parameter int unsigned HARD_FRAMES = 3200,
  localparam int unsigned CW = $clog2(LONG_ZEROS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic frame_tick,
  input  logic fas_lost,
  input  logic ais_rx,
  input  logic crc4_en,
  input  logic mf_found,
  input  logic auto_ais_en,
  input  logic auto_rai_en,
  input  logic long_zero_sel,
  output logic send_ais,
  output logic send_rai,
  output logic carrier_lost,
  output logic cfg_illegal
);
  logic [CW-1:0] zero_run;
  logic          mf_late;
  logic          mf_abandon;
  logic          rx_defect;

  e1_zero_run_det #(.SHORT_LIM(SHORT_ZEROS), .LONG_LIM(LONG_ZEROS)) u_zero (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .long_sel(long_zero_sel),
    .run_len(zero_run), .lost(carrier_lost)
  );

  e1_mf_search_timer #(.SOFT_FRAMES(SOFT_FRAMES), .HARD_FRAMES(HARD_FRAMES)) u_mf (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fas_lost(fas_lost),
    .crc4_en(crc4_en), .mf_found(mf_found), .late(mf_late), .abandon(mf_abandon)
  );

  assign rx_defect = fas_lost || ais_rx || carrier_lost;

  e1_alarm_arbiter u_arb (
    .auto_ais_en(auto_ais_en), .auto_rai_en(auto_rai_en), .crc4_en(crc4_en),
    .rx_defect(rx_defect), .mf_late(mf_late), .mf_abandon(mf_abandon),
    .send_ais(send_ais), .send_rai(send_rai), .cfg_illegal(cfg_illegal)
  );
endmodule

// File: rtl/e1_alarm_gen_checker.sv
module e1_alarm_gen_checker #(
  parameter int unsigned LONG_ZEROS = 2048,
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_bit,
  input logic          fas_lost,
  input logic          crc4_en,
  input logic          auto_ais_en,
  input logic          auto_rai_en,
  input logic          send_ais,
  input logic          send_rai,
  input logic          carrier_lost,
  input logic          cfg_illegal,
  input logic          mf_abandon,
  input logic [CW-1:0] zero_run
);
  assert_one_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit |=> !carrier_lost && zero_run == '0);

  assert_loss_after_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_lost) |-> $past(!rx_bit));

  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zero_run) <= LONG_ZEROS);

  assert_ais_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    send_ais |-> auto_ais_en);

  assert_ais_on_frame_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ais_en && fas_lost) |-> send_ais);

  assert_rai_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rai_en |-> !send_rai);

  assert_abandon_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_abandon && !fas_lost && crc4_en) |=> mf_abandon);

  assert_abandon_drives_rai_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_abandon && crc4_en && auto_rai_en && !auto_ais_en) |-> send_rai);

  assert_ais_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> !(send_ais && send_rai));
endmodule

bind e1_alarm_gen e1_alarm_gen_checker #(.LONG_ZEROS(LONG_ZEROS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .fas_lost(fas_lost), .crc4_en(crc4_en),
  .auto_ais_en(auto_ais_en), .auto_rai_en(auto_rai_en), .send_ais(send_ais),
  .send_rai(send_rai), .carrier_lost(carrier_lost), .cfg_illegal(cfg_illegal),
  .mf_abandon(mf_abandon), .zero_run(zero_run)
);

// File: tb/e1_alarm_gen_bench.sv
module e1_alarm_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, frame_tick = 1'b0, fas_lost = 1'b0, ais_rx = 1'b0;
  logic crc4_en = 1'b0, mf_found = 1'b0, auto_ais_en = 1'b0, auto_rai_en = 1'b0;
  logic long_zero_sel = 1'b0;
  logic send_ais, send_rai, carrier_lost, cfg_illegal;
  int total = 0, failed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  e1_alarm_gen u_e1_alarm_gen (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .frame_tick(frame_tick),
    .fas_lost(fas_lost), .ais_rx(ais_rx), .crc4_en(crc4_en), .mf_found(mf_found),
    .auto_ais_en(auto_ais_en), .auto_rai_en(auto_rai_en), .long_zero_sel(long_zero_sel),
    .send_ais(send_ais), .send_rai(send_rai), .carrier_lost(carrier_lost),
    .cfg_illegal(cfg_illegal)
  );

  task automatic check(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    frame_tick = 1'b1;
    cycles(n);
    frame_tick = 1'b0;
  endtask

  task automatic idle_inputs();
    rx_bit = 1'b1; frame_tick = 1'b0; fas_lost = 1'b0; ais_rx = 1'b0;
    crc4_en = 1'b0; mf_found = 1'b0; auto_ais_en = 1'b0; auto_rai_en = 1'b0;
    long_zero_sel = 1'b0;
    cycles(1);
  endtask

  task automatic t_reset();
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    check(send_ais, 1'b0, "R10 send_ais after reset");
    check(send_rai, 1'b0, "R10 send_rai after reset");
    check(carrier_lost, 1'b0, "R10 carrier_lost after reset");
    check(cfg_illegal, 1'b0, "R10 cfg_illegal after reset");
  endtask

  task automatic t_carrier_short();
    idle_inputs();
    rx_bit = 1'b0;
    cycles(254);
    check(carrier_lost, 1'b0, "R1 254 zeros");
    cycles(1);
    check(carrier_lost, 1'b1, "R1 255 zeros");
    rx_bit = 1'b1;
    cycles(1);
    check(carrier_lost, 1'b0, "R3 one clears loss");
    rx_bit = 1'b0;
    cycles(200);
    rx_bit = 1'b1;
    cycles(1);
    rx_bit = 1'b0;
    cycles(254);
    check(carrier_lost, 1'b0, "R3 run restarted after one");
    rx_bit = 1'b1;
    cycles(1);
  endtask

  task automatic t_carrier_long();
    idle_inputs();
    long_zero_sel = 1'b1;
    rx_bit = 1'b0;
    cycles(2047);
    check(carrier_lost, 1'b0, "R2 2047 zeros");
    cycles(1);
    check(carrier_lost, 1'b1, "R2 2048 zeros");
    auto_ais_en = 1'b1;
    #1;
    check(send_ais, 1'b1, "R4 AIS on carrier loss");
    rx_bit = 1'b1;
    cycles(1);
    check(send_ais, 1'b0, "R4 AIS drops with carrier back");
  endtask

  task automatic t_ais();
    idle_inputs();
    auto_ais_en = 1'b1;
    fas_lost = 1'b1;
    cycles(1);
    check(send_ais, 1'b1, "R4 AIS on frame loss");
    fas_lost = 1'b0; ais_rx = 1'b1;
    cycles(1);
    check(send_ais, 1'b1, "R4 AIS on all-ones received");
    ais_rx = 1'b0;
    cycles(1);
    check(send_ais, 1'b0, "R4 no defect no AIS");
    auto_ais_en = 1'b0; fas_lost = 1'b1;
    cycles(1);
    check(send_ais, 1'b0, "R4 AIS disabled");
    check(send_rai, 1'b0, "R5 RAI disabled");
  endtask

  task automatic t_rai();
    idle_inputs();
    auto_rai_en = 1'b1;
    fas_lost = 1'b1;
    cycles(1);
    check(send_rai, 1'b1, "R5 RAI on frame loss");
    check(cfg_illegal, 1'b0, "R9 single enable legal");
    fas_lost = 1'b0; ais_rx = 1'b1;
    cycles(1);
    check(send_rai, 1'b1, "R5 RAI on all-ones received");
    ais_rx = 1'b0;
    cycles(1);
    check(send_rai, 1'b0, "R5 no defect no RAI");
  endtask

  task automatic t_mf_soft();
    idle_inputs();
    auto_rai_en = 1'b1; crc4_en = 1'b1;
    ticks(1023);
    check(send_rai, 1'b0, "R6 1023 frames searching");
    ticks(1);
    check(send_rai, 1'b1, "R6 1024 frames searching");
    mf_found = 1'b1;
    cycles(1);
    check(send_rai, 1'b0, "R6 multiframe found clears RAI");
  endtask

  task automatic t_mf_gating();
    idle_inputs();
    auto_rai_en = 1'b1; crc4_en = 1'b1; fas_lost = 1'b1;
    ticks(1100);
    fas_lost = 1'b0;
    ticks(1023);
    check(send_rai, 1'b0, "R7 no count while frame lost");
    fas_lost = 1'b1;
    cycles(1);
    fas_lost = 1'b0;
    ticks(1000);
    check(send_rai, 1'b0, "R7 restart after frame loss");
    crc4_en = 1'b0;
    ticks(1100);
    check(send_rai, 1'b0, "R7 no timeout with CRC4 off");
  endtask

  task automatic t_mf_hard();
    idle_inputs();
    auto_rai_en = 1'b1; crc4_en = 1'b1;
    ticks(3199);
    check(send_rai, 1'b1, "R6 late search at 3199");
    mf_found = 1'b1;
    cycles(1);
    check(send_rai, 1'b0, "R8 still recoverable at 3199");
    mf_found = 1'b0;
    ticks(3200);
    check(send_rai, 1'b1, "R8 RAI at 3200");
    mf_found = 1'b1;
    cycles(2);
    check(send_rai, 1'b1, "R8 RAI constant after 3200");
    mf_found = 1'b0;
    ticks(5);
    mf_found = 1'b1;
    cycles(1);
    check(send_rai, 1'b1, "R8 still constant later");
    fas_lost = 1'b1;
    cycles(1);
    fas_lost = 1'b0;
    cycles(1);
    check(send_rai, 1'b0, "R8 frame loss releases constant RAI");
  endtask

  task automatic t_illegal();
    idle_inputs();
    auto_ais_en = 1'b1; auto_rai_en = 1'b1;
    cycles(1);
    check(cfg_illegal, 1'b1, "R9 both enables flagged");
    fas_lost = 1'b1;
    cycles(1);
    check(send_ais, 1'b1, "R9 AIS wins");
    check(send_rai, 1'b0, "R9 RAI suppressed");
    idle_inputs();
    check(cfg_illegal, 1'b0, "R9 flag clears");
    check(send_ais, 1'b0, "R10 neither enabled");
    check(send_rai, 1'b0, "R10 neither enabled rai");
  endtask

  initial begin
    t_reset();
    t_carrier_short();
    t_carrier_long();
    t_ais();
    t_rai();
    t_mf_soft();
    t_mf_gating();
    t_mf_hard();
    t_illegal();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule